// File: doc/BRIEF.md
# Dual-Tone Melody Sequencer

This block plays tunes held as lists of packed note words. A host loads a note store of up to 1024 words of 22 bits, plus a small table that gives, for each song number, the address of that song's first note. A start command with a nonzero song number makes the sequencer walk the list from that address. It decodes each word into two pitch codes, a beat code and an effect, and holds the note for a time set by the beat code and a tempo value. It stops after a word that carries the end-of-song bit.

Two square-wave channels run at once, one per output pin. A note can ask for tremolo, which gates both pins on and off, or for triple frequency, which divides each channel's half period by three. A note can also ask for one of three percussion kinds, which the block reports as a code on a separate output and does not synthesize. A latched mode bit chooses whether the busy flag and the interrupt pulse follow every note or the whole song. A stop command silences the block on the next clock.

Top module: `mel_sequencer`

## Requirements
- R1: When `wr_en` is high and `wr_sel` is 0, `wr_data` is written into note address `wr_addr`. When `wr_sel` is 1, `wr_data[9:0]` becomes the start address of song `wr_addr[4:0]`. Both writes take effect at the clock edge.
- R2: In the idle state, `start_i` with `song_i` nonzero begins playback at the table address of that song and latches `tempo_i` and `mode_i`. A start with song 0, or a start while a song is active, has no effect.
- R3: A note word is packed as pitch of channel A in [21:16], pitch of channel B in [15:10], beat code in [9:7], effect in [6:5] (0 none, 1 tremolo, 2 triple, 3 percussion), percussion kind in [4:3], end-of-song in [2]. Bits [1:0] are ignored.
- R4: A note sounds for units × (tempo+1) × TICK_CLKS clocks. Beat codes 0 to 5 give 1, 2, 3, 4, 6 and 8 units, and codes 6 and 7 give 1 unit. One fetch clock separates notes, and successive notes come from consecutive addresses that wrap from 1023 to 0.
- R5: A pitch code p in 1..41 gives a square wave with a half period of HALF_MIN + (41 − p) × HALF_STEP clocks. The wave starts low on the first clock of the note. Code 0 and codes above 41 are rests, and a rest keeps the pin low.
- R6: With effect 2 (triple), the half period of each channel is the R5 value divided by three, rounded down, with a minimum of 1.
- R7: With effect 1 (tremolo), both pins are allowed to sound during the first TP clocks of the note, are held low for the next TP clocks, and so on, where TP = TREM_TICKS × TICK_CLKS × (tempo+1).
- R8: While a note with effect 3 plays, `perc_o` shows kind+1 for kinds 0 to 2 and 0 for kind 3. At all other times `perc_o` is 0.
- R9: After the last clock of a note with the end-of-song bit set, the block returns to idle with both pins low.
- R10: In mode 0 (per song), `busy_o` is high from the clock after an accepted start until the song ends. In mode 1 (per note), `busy_o` is high only while a note sounds.
- R11: `irq_o` is a one-clock pulse in the clock after the last sounding clock of every note (mode 1) or of the song's last note (mode 0).
- R12: `stop_i` in any state makes the next clock idle, with both pins low, busy low and no interrupt. It takes priority over a simultaneous start.
- R13: While `rst` is high, and on the clock after it, the pins, `perc_o`, `busy_o` and `irq_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0: note store, 1: song table |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 22 | Write data |
| start_i | input | 1 | Start command |
| song_i | input | SONG_W | Song number for start |
| stop_i | input | 1 | Stop command |
| tempo_i | input | 4 | Tempo setting, latched at start |
| mode_i | input | 1 | Busy/interrupt mode, latched at start |
| tone_a_o | output | 1 | Speaker pin of channel A |
| tone_b_o | output | 1 | Speaker pin of channel B |
| perc_o | output | 2 | Percussion code of the current note |
| busy_o | output | 1 | Busy flag |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with TICK_CLKS = 2, HALF_MIN = 3, HALF_STEP = 1 and TREM_TICKS = 2, and keeps the full 10-bit note address. With these values a note lasts between 2 and 256 clocks, so whole songs, tremolo windows and the longest tempo finish in a few hundred cycles. The short half periods make the rounding of the triple division to 1 visible. The full address width still lets a song run from address 1023 across the wrap to 0.

// File: rtl/mel_pkg.sv
package mel_pkg;

   localparam int unsigned NOTE_W    = 22;
   localparam int unsigned PITCH_W   = 6;
   localparam int unsigned PITCH_TOP = 41;   // highest sounding pitch code
   localparam int unsigned TEMPO_W   = 4;
   localparam int unsigned MAX_UNITS = 8;

   typedef enum logic [1:0] {
      FX_NONE   = 2'd0,
      FX_TREM   = 2'd1,
      FX_TRIPLE = 2'd2,
      FX_PERC   = 2'd3
   } fx_e;

   typedef struct packed {
      logic [PITCH_W-1:0] pitch_a;
      logic [PITCH_W-1:0] pitch_b;
      logic [2:0]         beat;
      fx_e                fx;
      logic [1:0]         perc;
      logic               last;
      logic [1:0]         rsvd;
   } note_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_PLAY  = 2'd2
   } seq_st_e;

   function automatic int unsigned beat_units(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 3;
         3'd3:    return 4;
         3'd4:    return 6;
         3'd5:    return 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/mel_note_store.sv
module mel_note_store
   import mel_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned SONG_W = 5
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NOTE_W-1:0] wr_data,
   input  logic [SONG_W-1:0] song_i,
   output logic [ADDR_W-1:0] song_base_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output note_t             note_o
);

   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned SONGS = 1 << SONG_W;

   logic [NOTE_W-1:0] mem_q [DEPTH];
   logic [ADDR_W-1:0] tbl_q [SONGS];

   // R1
   always_ff @(posedge clk) begin
      if (wr_en && !wr_sel) mem_q[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_sel) tbl_q[wr_addr[SONG_W-1:0]] <= wr_data[ADDR_W-1:0];
   end

   assign song_base_o = tbl_q[song_i];
   assign note_o      = note_t'(mem_q[rd_addr_i]);

endmodule

// File: rtl/mel_tone_chan.sv
module mel_tone_chan
   import mel_pkg::*;
#(
   parameter int unsigned HALF_MIN  = 1000,
   parameter int unsigned HALF_STEP = 60,
   localparam int unsigned HALF_MAX = HALF_MIN + PITCH_TOP * HALF_STEP,
   localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_i,
   input  logic               run_i,
   input  logic [PITCH_W-1:0] pitch_i,
   input  logic               triple_i,
   input  logic               gate_i,
   output logic               tone_o
);

   logic              pitch_ok;
   int unsigned       base_len;
   int unsigned       use_len;
   logic [HALF_W-1:0] half_len;
   logic [HALF_W-1:0] cnt_q;
   logic              ph_q;

   assign pitch_ok = (pitch_i != '0) && (pitch_i <= PITCH_W'(PITCH_TOP));

   always_comb begin
      if (pitch_ok) base_len = HALF_MIN + (PITCH_TOP - 32'(pitch_i)) * HALF_STEP;
      else          base_len = HALF_MIN;
      if (triple_i) use_len = (base_len / 3 == 0) ? 32'd1 : base_len / 3;
      else          use_len = base_len;
      half_len = HALF_W'(use_len);
   end

   always_ff @(posedge clk) begin
      if (rst || load_i) begin
         cnt_q <= '0;
         ph_q  <= 1'b0;
      end else if (run_i) begin
         if (cnt_q == half_len - 1'b1) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tone_o = run_i && pitch_ok && gate_i && ph_q;

   // R5
   ph_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run_i && !load_i && cnt_q != half_len - 1'b1) |=> $stable(ph_q));

   // R6
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      run_i |-> (cnt_q < half_len));

endmodule

// File: rtl/mel_seq_ctrl.sv
module mel_seq_ctrl
   import mel_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned SONG_W     = 5,
   parameter int unsigned TICK_CLKS  = 100000,
   parameter int unsigned TREM_TICKS = 2,
   localparam int unsigned DUR_MAX   = MAX_UNITS * (1 << TEMPO_W) * TICK_CLKS,
   localparam int unsigned DUR_W     = $clog2(DUR_MAX + 1),
   localparam int unsigned TREM_MAX  = TREM_TICKS * TICK_CLKS * (1 << TEMPO_W),
   localparam int unsigned TREM_W    = $clog2(TREM_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_i,
   input  logic [SONG_W-1:0]  song_i,
   input  logic               stop_i,
   input  logic [TEMPO_W-1:0] tempo_i,
   input  logic               mode_i,
   input  logic [ADDR_W-1:0]  song_base_i,
   input  note_t              note_i,
   output logic [ADDR_W-1:0]  rd_addr_o,
   output note_t              note_o,
   output logic               load_o,
   output logic               run_o,
   output logic               gate_o,
   output logic [1:0]         perc_o,
   output logic               busy_o,
   output logic               irq_o
);

   seq_st_e            st_q;
   logic [ADDR_W-1:0]  addr_q;
   note_t              note_q;
   logic [DUR_W-1:0]   dur_q;
   logic [DUR_W-1:0]   dur_load;
   logic [TEMPO_W-1:0] tempo_q;
   logic               mode_q;
   logic [TREM_W-1:0]  trem_cnt_q;
   logic [TREM_W-1:0]  trem_len;
   logic               gate_q;
   logic               irq_q;

   // R4
   assign dur_load = DUR_W'(beat_units(note_i.beat) * (32'(tempo_q) + 32'd1) * TICK_CLKS - 32'd1);
   // R7
   assign trem_len = TREM_W'(TREM_TICKS * TICK_CLKS * (32'(tempo_q) + 32'd1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         note_q     <= '0;
         dur_q      <= '0;
         tempo_q    <= '0;
         mode_q     <= 1'b0;
         trem_cnt_q <= '0;
         gate_q     <= 1'b1;
         irq_q      <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (stop_i) begin
            st_q <= ST_IDLE;
         end else begin
            case (st_q)
               ST_IDLE: begin
                  if (start_i && song_i != '0) begin
                     addr_q  <= song_base_i;
                     tempo_q <= tempo_i;
                     mode_q  <= mode_i;
                     st_q    <= ST_FETCH;
                  end
               end
               ST_FETCH: begin
                  note_q     <= note_i;
                  dur_q      <= dur_load;
                  trem_cnt_q <= '0;
                  gate_q     <= 1'b1;
                  st_q       <= ST_PLAY;
               end
               ST_PLAY: begin
                  if (trem_cnt_q == trem_len - 1'b1) begin
                     trem_cnt_q <= '0;
                     gate_q     <= ~gate_q;
                  end else begin
                     trem_cnt_q <= trem_cnt_q + 1'b1;
                  end
                  if (dur_q == '0) begin
                     irq_q <= note_q.last | mode_q;
                     if (note_q.last) begin
                        st_q <= ST_IDLE;
                     end else begin
                        addr_q <= addr_q + 1'b1;
                        st_q   <= ST_FETCH;
                     end
                  end else begin
                     dur_q <= dur_q - 1'b1;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign rd_addr_o = addr_q;
   assign note_o    = note_q;
   assign load_o    = (st_q == ST_FETCH);
   assign run_o     = (st_q == ST_PLAY);
   assign gate_o    = (note_q.fx != FX_TREM) || gate_q;
   assign perc_o    = (run_o && note_q.fx == FX_PERC && note_q.perc != 2'd3) ?
                      note_q.perc + 2'd1 : 2'd0;
   assign busy_o    = mode_q ? (st_q == ST_PLAY) : (st_q != ST_IDLE);
   assign irq_o     = irq_q;

   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !(start_i && song_i != '0)) |=> (st_q == ST_IDLE));

   // R4
   dur_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_PLAY && dur_q != '0 && !stop_i) |=> (st_q == ST_PLAY));

   // R10
   song_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_o && !mode_q) |-> !busy_o);

   // R11
   irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o |=> !irq_o);

   // R12
   stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
      stop_i |=> (st_q == ST_IDLE && !irq_o));

endmodule

// File: rtl/mel_sequencer.sv
module mel_sequencer
   import mel_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned SONG_W     = 5,
   parameter int unsigned TICK_CLKS  = 100000,
   parameter int unsigned HALF_MIN   = 1000,
   parameter int unsigned HALF_STEP  = 60,
   parameter int unsigned TREM_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [21:0]       wr_data,
   input  logic              start_i,
   input  logic [SONG_W-1:0] song_i,
   input  logic              stop_i,
   input  logic [3:0]        tempo_i,
   input  logic              mode_i,
   output logic              tone_a_o,
   output logic              tone_b_o,
   output logic [1:0]        perc_o,
   output logic              busy_o,
   output logic              irq_o
);

   localparam int unsigned N_CHAN = 2;

   if (SONG_W > ADDR_W) begin : g_bad_song_w
      $error("SONG_W must not exceed ADDR_W");
   end
   if (ADDR_W > NOTE_W) begin : g_bad_addr_w
      $error("ADDR_W must fit in a write word");
   end
   if (TICK_CLKS < 1 || TREM_TICKS < 1 || HALF_MIN < 1) begin : g_bad_timing
      $error("timing parameters must be at least 1");
   end

   logic [ADDR_W-1:0]  song_base;
   logic [ADDR_W-1:0]  rd_addr;
   note_t              note_rd;
   note_t              note_q;
   logic               load;
   logic               run;
   logic               gate;
   logic               triple;
   logic [PITCH_W-1:0] pitch_v [N_CHAN];
   logic [N_CHAN-1:0]  tone_v;
   logic               unused_bits;

   mel_note_store #(
      .ADDR_W (ADDR_W),
      .SONG_W (SONG_W)
   ) u_store (
      .clk         (clk),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .song_i      (song_i),
      .song_base_o (song_base),
      .rd_addr_i   (rd_addr),
      .note_o      (note_rd)
   );

   mel_seq_ctrl #(
      .ADDR_W     (ADDR_W),
      .SONG_W     (SONG_W),
      .TICK_CLKS  (TICK_CLKS),
      .TREM_TICKS (TREM_TICKS)
   ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start_i),
      .song_i      (song_i),
      .stop_i      (stop_i),
      .tempo_i     (tempo_i),
      .mode_i      (mode_i),
      .song_base_i (song_base),
      .note_i      (note_rd),
      .rd_addr_o   (rd_addr),
      .note_o      (note_q),
      .load_o      (load),
      .run_o       (run),
      .gate_o      (gate),
      .perc_o      (perc_o),
      .busy_o      (busy_o),
      .irq_o       (irq_o)
   );

   assign triple      = (note_q.fx == FX_TRIPLE);
   assign pitch_v[0]  = note_q.pitch_a;
   assign pitch_v[1]  = note_q.pitch_b;
   assign unused_bits = ^{note_q.beat, note_q.rsvd};

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      mel_tone_chan #(
         .HALF_MIN  (HALF_MIN),
         .HALF_STEP (HALF_STEP)
      ) u_chan (
         .clk      (clk),
         .rst      (rst),
         .load_i   (load),
         .run_i    (run),
         .pitch_i  (pitch_v[c]),
         .triple_i (triple),
         .gate_i   (gate),
         .tone_o   (tone_v[c])
      );
   end

   assign tone_a_o = tone_v[0];
   assign tone_b_o = tone_v[1];

   // R12
   stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      stop_i |=> (!tone_a_o && !tone_b_o && !busy_o && perc_o == 2'd0));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && !load && !run) |-> (!tone_a_o && !tone_b_o));

endmodule

// File: tb/sim_mel_sequencer.sv
module sim_mel_sequencer;

   localparam int ADDR_W = 10;
   localparam int SONG_W = 5;
   localparam int TICK   = 2;
   localparam int HMIN   = 3;
   localparam int HSTEP  = 1;
   localparam int TREM   = 2;
   localparam int TOP    = 41;

   logic              clk = 1'b0;
   logic              rst;
   logic              wr_en, wr_sel;
   logic [ADDR_W-1:0] wr_addr;
   logic [21:0]       wr_data;
   logic              start_i, stop_i, mode_i;
   logic [SONG_W-1:0] song_i;
   logic [3:0]        tempo_i;
   logic              tone_a_o, tone_b_o, busy_o, irq_o;
   logic [1:0]        perc_o;

   always #10 clk = ~clk;

   mel_sequencer #(
      .ADDR_W (ADDR_W), .SONG_W (SONG_W), .TICK_CLKS (TICK),
      .HALF_MIN (HMIN), .HALF_STEP (HSTEP), .TREM_TICKS (TREM)
   ) u0 (
      .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel),
      .wr_addr (wr_addr), .wr_data (wr_data), .start_i (start_i),
      .song_i (song_i), .stop_i (stop_i), .tempo_i (tempo_i), .mode_i (mode_i),
      .tone_a_o (tone_a_o), .tone_b_o (tone_b_o), .perc_o (perc_o),
      .busy_o (busy_o), .irq_o (irq_o)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   bit    cmp_on = 0;
   bit    done = 0;
   string tag = "R13 reset";

   // behavioural reference model
   int m_mem [1024];
   int m_tbl [32];
   int mst = 0, maddr = 0, mtempo = 0, mmode = 0, mnote = 0, mdur = 1, me = 0;
   bit mirq = 0;

   function automatic int units(int b);
      case (b)
         0: return 1; 1: return 2; 2: return 3;
         3: return 4; 4: return 6; 5: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic bit exp_tone(int code, int fx, int e, int tempo);
      int h, tp;
      if (code == 0 || code > TOP) return 1'b0;
      h = HMIN + (TOP - code) * HSTEP;
      if (fx == 2) begin
         h = h / 3;
         if (h == 0) h = 1;
      end
      if (fx == 1) begin
         tp = TREM * TICK * (tempo + 1);
         if (((e / tp) % 2) != 0) return 1'b0;
      end
      return ((e / h) % 2) != 0;
   endfunction

   function automatic logic [21:0] mk(int pa, int pb, int bt, int fx, int pt, int last);
      return {6'(pa), 6'(pb), 3'(bt), 2'(fx), 2'(pt), 1'(last), 2'b00};
   endfunction

   always @(posedge clk) begin
      bit nirq;
      if (rst) begin
         mst = 0; mirq = 0; mmode = 0;
      end else begin
         nirq = 0;
         if (stop_i) begin
            mst = 0;
         end else if (mst == 0) begin
            if (start_i && song_i != 0) begin
               maddr = m_tbl[song_i]; mtempo = int'(tempo_i); mmode = int'(mode_i); mst = 1;
            end
         end else if (mst == 1) begin
            mnote = m_mem[maddr];
            mdur  = units((mnote >> 7) & 7) * (mtempo + 1) * TICK;
            me    = 0;
            mst   = 2;
         end else begin
            if (me == mdur - 1) begin
               if (((mnote >> 2) & 1) != 0) begin
                  mst = 0; nirq = 1;
               end else begin
                  maddr = (maddr + 1) % 1024; mst = 1; nirq = (mmode != 0);
               end
            end else begin
               me++;
            end
         end
         mirq = nirq;
      end
      if (wr_en) begin
         if (wr_sel) m_tbl[int'(wr_addr) % 32] = int'(wr_data) % 1024;
         else        m_mem[wr_addr] = int'(wr_data);
      end
   end

   task automatic chk(string what, logic [3:0] act, logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL [%s] %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int fx, pt;
      bit ea, eb, ebusy;
      logic [1:0] ep;
      if (cmp_on && !done) begin
         fx = (mnote >> 5) & 3;
         pt = (mnote >> 3) & 3;
         ea = 0; eb = 0; ep = 2'd0;
         if (mst == 2) begin
            ea = exp_tone((mnote >> 16) & 63, fx, me, mtempo);
            eb = exp_tone((mnote >> 10) & 63, fx, me, mtempo);
            if (fx == 3 && pt != 3) ep = 2'(pt + 1);
         end
         ebusy = (mmode != 0) ? (mst == 2) : (mst != 0);
         chk("tone_a R5 R6 R7", {3'b0, tone_a_o}, {3'b0, ea});
         chk("tone_b R5 R6 R7", {3'b0, tone_b_o}, {3'b0, eb});
         chk("perc R8", {2'b0, perc_o}, {2'b0, ep});
         chk("busy R10", {3'b0, busy_o}, {3'b0, ebusy});
         chk("irq R11", {3'b0, irq_o}, {3'b0, mirq});
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_bad++;
         $display("FAIL [%s] watchdog expired", tag);
         finish_run();
      end
   end

   task automatic wr(bit sel, int addr, logic [21:0] data);
      wr_en = 1; wr_sel = sel; wr_addr = ADDR_W'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic go(int song, int tempo, bit mode);
      start_i = 1; song_i = SONG_W'(song); tempo_i = 4'(tempo); mode_i = mode;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (mst != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      rst = 1; wr_en = 0; wr_sel = 0; wr_addr = '0; wr_data = '0;
      start_i = 0; stop_i = 0; song_i = '0; tempo_i = '0; mode_i = 0;
      @(posedge clk);
      cmp_on = 1;
      repeat (3) @(negedge clk);
      rst = 0;
      repeat (2) @(negedge clk);

      tag = "R1 R3 loading";
      wr(1, 1, 22'd0);
      wr(0, 0, mk(41, 38, 0, 0, 0, 0));
      wr(0, 1, mk(30, 0, 5, 0, 0, 0));
      wr(0, 2, mk(40, 35, 1, 2, 0, 0));
      wr(0, 3, mk(20, 41, 2, 1, 0, 1));
      wr(1, 2, 22'd20);
      wr(0, 20, mk(10, 0, 3, 3, 0, 0));
      wr(0, 21, mk(50, 63, 4, 3, 2, 0));
      wr(0, 22, mk(25, 12, 6, 3, 3, 0));
      wr(0, 23, mk(41, 41, 7, 0, 0, 1) | 22'd3);
      wr(1, 3, 22'd1022);
      wr(0, 1022, mk(5, 6, 0, 0, 0, 0));
      wr(0, 1023, mk(7, 8, 1, 0, 0, 0));
      wr(1, 31, 22'd40);
      wr(0, 40, mk(15, 16, 5, 0, 0, 1));

      tag = "R2 R3 R4 R5 R6 R7 R9 song mode R10 R11";
      go(1, 2, 0);
      wait_idle();

      tag = "R2 song zero ignored";
      go(0, 1, 0);
      repeat (10) @(negedge clk);

      tag = "R4 R8 note mode R10 R11";
      go(2, 3, 1);
      wait_idle();

      tag = "R4 address wrap";
      go(3, 0, 1);
      wait_idle();

      tag = "R2 start ignored while busy";
      go(31, 15, 0);
      repeat (20) @(negedge clk);
      go(1, 0, 1);
      repeat (20) @(negedge clk);

      tag = "R12 stop beats start";
      stop_i = 1; start_i = 1; song_i = 5'd2;
      @(negedge clk);
      stop_i = 0; start_i = 0;
      repeat (10) @(negedge clk);

      tag = "R1 table rewrite";
      wr(1, 31, 22'd20);
      go(31, 0, 0);
      wait_idle();

      tag = "R13 reset mid-song";
      go(1, 1, 1);
      repeat (15) @(negedge clk);
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      repeat (10) @(negedge clk);

      finish_run();
   end

endmodule